// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a main-memory port. It keeps eight one-word lines, indexed directly by the low bits of the word address. Each line holds a valid bit, a dirty bit, the upper address bits as a tag, and one data word. A read that hits completes in the cycle it is presented. A read that misses stalls the processor while the word is fetched and written into the line. A write updates the line and marks it dirty, and it never reads memory.

A dirty line is written back by a background engine. The engine starts a memory write only in a cycle in which the processor is not writing into the cache. It scans for dirty lines in round-robin order. A miss whose line is still dirty holds the processor until the engine has cleaned that line, so an eviction never needs its own write-back. A flush pulse makes the block drain every dirty line and then drop all lines.

The memory side allows one request at a time. The request is held until memory acknowledges it for one cycle.

Top module: `dm_wb_cache`

## Requirements
- R1: The line index is the word address modulo 8 (cpu_addr[2:0]) and the tag is cpu_addr[7:3]. Addresses 0, 8 and 16 therefore compete for line 0, and each of them evicts the others.
- R2: cpu_hit is high while cpu_valid is high and the indexed line is valid with a stored tag equal to the request tag. It is low otherwise.
- R3: After reset no line is valid, so the first access to any address misses, including address 0 with an all-zero tag.
- R4: A read hit raises cpu_ready in the cycle it is presented, with the line's word on cpu_rdata, and starts no memory transaction.
- R5: A read miss on a clean or empty line issues exactly one memory read (mem_we=0) of that address and fills the line with the returned word. The request then completes with cpu_hit=1, cpu_ready=1 and that word.
- R6: A write hit replaces the word and marks the line dirty. A write miss on a clean or empty line installs the new tag and word in the cycle it is presented, marked dirty, with no memory read. Both complete with cpu_ready=1.
- R7: A dirty line is never overwritten under a different tag. A miss that maps to a dirty line waits until that line has been written back, and memory then holds the dirty word.
- R8: A write-back (mem_we=1) starts only at a clock edge where no processor write is accepted. It carries the line's tag, index and word, and the dirty bit clears on mem_ack. A line is not written by the processor while its write-back is outstanding.
- R9: A one-cycle flush_req raises flush_busy from the next cycle on. While flush_busy is high, cpu_ready stays low and every dirty line is written back. After that all lines become invalid and flush_busy falls, so the next access misses.
- R10: The write-back engine picks the first dirty index at or after one past the index it last cleaned, wrapping modulo 8. After reset it starts its search at index 0.
- R11: At most one memory transaction is outstanding. mem_req, mem_we and mem_addr stay stable until a one-cycle mem_ack, and mem_req falls after that ack. When a read fill and a write-back could both start at the same edge, the fill starts.
- R12: cpu_ready is never high without cpu_valid, and it stays low during every stall, including the whole of a read fill. The request inputs must be held until cpu_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_hit | output | 1 | Lookup of the current request hits |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready on a load |
| flush_req | input | 1 | Pulse to start a flush |
| flush_busy | output | 1 | Flush in progress |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
A wrong valid bit or tag shows at once as a wrong cpu_hit in the first cycle of the next access to that index. The bench predicts every hit from its own model of the tags. A lost or stale dirty bit stays hidden until the line is evicted or flushed. It then appears as a stale word in memory or on a later read, so the bench compares all of memory against its golden copy after idle periods and after each flush. A wrong write-back pointer or a wrong arbitration choice shows up on the first memory request that follows, and a monitor checks the index and timing of every request it sees.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [1:0] {
      MEM_IDLE  = 2'd0,
      MEM_FILL  = 2'd1,
      MEM_CLEAN = 2'd2
   } mem_state_e;

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
   parameter int LINES  = 8,
   parameter int TAG_W  = 5,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output logic              lk_valid,
   output logic              lk_dirty,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [DATA_W-1:0] lk_data,
   input  logic [IDX_W-1:0]  cl_idx,
   output logic [TAG_W-1:0]  cl_tag,
   output logic [DATA_W-1:0] cl_data,
   output logic [LINES-1:0]  dirty_vec,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [TAG_W-1:0]  w_tag,
   input  logic [DATA_W-1:0] w_data,
   input  logic              w_dirty,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic              inv_all
);

   logic              vld_q [LINES];
   logic              drt_q [LINES];
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [DATA_W-1:0] dat_q [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            drt_q[i] <= 1'b0;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
         end else if (inv_all) begin
            vld_q[i] <= 1'b0;
            drt_q[i] <= 1'b0;
         end else if (we && w_idx == IDX_W'(i)) begin
            vld_q[i] <= 1'b1;
            drt_q[i] <= w_dirty;
            tag_q[i] <= w_tag;
            dat_q[i] <= w_data;
         end else if (clr_en && clr_idx == IDX_W'(i)) begin
            drt_q[i] <= 1'b0;
         end
      end
      assign dirty_vec[i] = drt_q[i];
   end

   assign lk_valid = vld_q[lk_idx];
   assign lk_dirty = drt_q[lk_idx];
   assign lk_tag   = tag_q[lk_idx];
   assign lk_data  = dat_q[lk_idx];
   assign cl_tag   = tag_q[cl_idx];
   assign cl_data  = dat_q[cl_idx];

   // R8: a write-back completion only ever cleans a line that is dirty
   p_clean_hits_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> drt_q[clr_idx])
      else $error("write-back cleared a line that was not dirty");

   // R7: a fill never lands on a dirty line
   p_fill_on_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !w_dirty) |-> !drt_q[w_idx])
      else $error("fill overwrote a dirty line");

   // R7: a dirty line is only rewritten under its own tag
   p_keep_dirty_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && drt_q[w_idx]) |-> (tag_q[w_idx] == w_tag))
      else $error("dirty line replaced under another tag");

endmodule

// File: rtl/dmc_rr_picker.sv
module dmc_rr_picker #(
   parameter int LINES = 8,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] dirty,
   input  logic             take,
   output logic             any,
   output logic [IDX_W-1:0] sel
);

   logic [IDX_W-1:0] ptr_q;

   always_comb begin
      logic [IDX_W-1:0] cand;
      any = 1'b0;
      sel = '0;
      for (int k = 0; k < LINES; k++) begin
         cand = ptr_q + IDX_W'(k);
         if (!any && dirty[cand]) begin
            any = 1'b1;
            sel = cand;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (take) ptr_q <= sel + 1'b1;
   end

   // R10: the engine only launches on a line that is dirty
   p_pick_is_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> dirty[sel])
      else $error("write-back launched on a clean line");

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
   import dmc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              flush_req,
   output logic              flush_busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0]  req_idx;
   logic [TAG_W-1:0]  req_tag;
   logic              lk_valid, lk_dirty;
   logic [TAG_W-1:0]  lk_tag, cl_tag;
   logic [DATA_W-1:0] lk_data, cl_data;
   logic [LINES-1:0]  dirty_vec;
   logic              pk_any;
   logic [IDX_W-1:0]  pk_sel;

   mem_state_e        mst_q;
   logic              flush_q;
   logic [IDX_W-1:0]  cln_idx_q;
   logic              req_q, we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   logic hit, blocked_wr, rd_ok, wr_ok, wr_accept, need_fill;
   logic fill_done, clean_done, take, inv_all;
   logic              arr_we, arr_dirty;
   logic [IDX_W-1:0]  arr_idx;
   logic [TAG_W-1:0]  arr_tag;
   logic [DATA_W-1:0] arr_data;

   assign req_idx = cpu_addr[IDX_W-1:0];
   assign req_tag = cpu_addr[ADDR_W-1:IDX_W];

   // lookup and processor-side acceptance
   assign hit        = lk_valid && (lk_tag == req_tag);
   assign blocked_wr = (mst_q == MEM_CLEAN) && (cln_idx_q == req_idx);
   assign rd_ok      = !cpu_write && hit;
   assign wr_ok      = cpu_write && (hit || !lk_dirty) && !blocked_wr;
   assign cpu_ready  = cpu_valid && !flush_q && (mst_q != MEM_FILL) && (rd_ok || wr_ok);
   assign cpu_hit    = cpu_valid && hit;
   assign cpu_rdata  = lk_data;
   assign wr_accept  = cpu_ready && cpu_write;
   assign need_fill  = cpu_valid && !cpu_write && !hit && !lk_dirty && !flush_q;

   // memory-side arbitration: demand fill first, then background write-back
   assign fill_done  = (mst_q == MEM_FILL)  && mem_ack;
   assign clean_done = (mst_q == MEM_CLEAN) && mem_ack;
   assign take       = (mst_q == MEM_IDLE) && !need_fill && pk_any && !wr_accept;
   assign inv_all    = flush_q && (mst_q == MEM_IDLE) && !pk_any;

   // single write port of the line store: fill or processor store
   assign arr_we    = wr_accept || fill_done;
   assign arr_idx   = fill_done ? addr_q[IDX_W-1:0]      : req_idx;
   assign arr_tag   = fill_done ? addr_q[ADDR_W-1:IDX_W] : req_tag;
   assign arr_data  = fill_done ? mem_rdata              : cpu_wdata;
   assign arr_dirty = !fill_done;

   dmc_line_store #(
      .LINES (LINES),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (req_idx),
      .lk_valid (lk_valid),
      .lk_dirty (lk_dirty),
      .lk_tag   (lk_tag),
      .lk_data  (lk_data),
      .cl_idx   (pk_sel),
      .cl_tag   (cl_tag),
      .cl_data  (cl_data),
      .dirty_vec(dirty_vec),
      .we       (arr_we),
      .w_idx    (arr_idx),
      .w_tag    (arr_tag),
      .w_data   (arr_data),
      .w_dirty  (arr_dirty),
      .clr_en   (clean_done),
      .clr_idx  (cln_idx_q),
      .inv_all  (inv_all)
   );

   dmc_rr_picker #(
      .LINES(LINES),
      .IDX_W(IDX_W)
   ) u_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .dirty(dirty_vec),
      .take (take),
      .any  (pk_any),
      .sel  (pk_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_q     <= MEM_IDLE;
         req_q     <= 1'b0;
         we_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         cln_idx_q <= '0;
      end else begin
         unique case (mst_q)
            MEM_IDLE: begin
               if (need_fill) begin
                  mst_q  <= MEM_FILL;
                  req_q  <= 1'b1;
                  we_q   <= 1'b0;
                  addr_q <= cpu_addr;
               end else if (take) begin
                  mst_q     <= MEM_CLEAN;
                  req_q     <= 1'b1;
                  we_q      <= 1'b1;
                  addr_q    <= {cl_tag, pk_sel};
                  wdata_q   <= cl_data;
                  cln_idx_q <= pk_sel;
               end
            end
            MEM_FILL, MEM_CLEAN: begin
               if (mem_ack) begin
                  mst_q <= MEM_IDLE;
                  req_q <= 1'b0;
               end
            end
            default: mst_q <= MEM_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flush_q <= 1'b0;
      else if (inv_all)              flush_q <= 1'b0;
      else if (flush_req)            flush_q <= 1'b1;
   end

   assign flush_busy = flush_q;
   assign mem_req    = req_q;
   assign mem_we     = we_q;
   assign mem_addr   = addr_q;
   assign mem_wdata  = wdata_q;

   p_quiet_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && mst_q == MEM_IDLE) |=> (mst_q != MEM_CLEAN))
      else $error("write-back started on a store cycle");

   p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
      else $error("memory request changed before acknowledge");

   p_fill_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_q == MEM_IDLE && need_fill) |=> (mem_req && !mem_we))
      else $error("fill lost arbitration");

   p_stall_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_q == MEM_FILL) |-> !cpu_ready)
      else $error("ready during fill");

   p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |-> !cpu_ready)
      else $error("ready during flush");

endmodule

// File: tb/tb_dm_wb_cache.sv
module tb_dm_wb_cache;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int LINES  = 8;
   localparam int LAT    = 3;
   localparam int DEPTH  = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_valid = 1'b0, cpu_write = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic              cpu_ready, cpu_hit;
   logic [DATA_W-1:0] cpu_rdata;
   logic              flush_req = 1'b0, flush_busy;
   logic              mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_ack;
   logic [DATA_W-1:0] mem_rdata;

   always #10 clk = ~clk;

   dm_wb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
      .cpu_rdata(cpu_rdata), .flush_req(flush_req), .flush_busy(flush_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] seed(int a);
      return 32'hA500_0000 ^ (32'(a) * 32'h0101_0101);
   endfunction

   // memory model with fixed latency
   logic [31:0] mem [DEPTH];
   int          lat_cnt;
   logic        ack_q;
   logic [31:0] rdata_q;

   always @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         lat_cnt <= 0;
         rdata_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= seed(i);
      end else if (ack_q) begin
         ack_q <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt == LAT) begin
            ack_q   <= 1'b1;
            lat_cnt <= 0;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        rdata_q <= mem[mem_addr];
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end
   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;

   // port monitor: transaction order and timing
   int         mon_checks = 0, mon_errors = 0, rd_cnt = 0;
   logic       prev_req, prev_acc, outst;
   logic [7:0] sdirty;
   int         last_cl;

   always @(negedge clk) begin
      logic acc;
      int   exp_i;
      logic found;
      if (!rst_n) begin
         prev_req = 1'b0; prev_acc = 1'b0; outst = 1'b0;
         sdirty = '0; last_cl = LINES - 1; rd_cnt = 0;
      end else begin
         acc = cpu_valid && cpu_write && cpu_ready;
         if (cpu_ready && !cpu_valid) begin
            mon_checks++; mon_errors++;
            $display("FAIL R12 ready without valid actual=1 expected=0");
         end
         if (mem_req && !prev_req) begin
            mon_checks++;
            if (outst) begin
               mon_errors++;
               $display("FAIL R11 new request before ack actual=%0d expected=0", outst);
            end
            outst = 1'b1;
            if (mem_we) begin
               found = 1'b0; exp_i = 0;
               for (int k = 1; k <= LINES; k++) begin
                  if (!found && sdirty[(last_cl + k) % LINES]) begin
                     found = 1'b1; exp_i = (last_cl + k) % LINES;
                  end
               end
               mon_checks++;
               if (int'(mem_addr[2:0]) != exp_i) begin
                  mon_errors++;
                  $display("FAIL R10 write-back index actual=%0d expected=%0d", mem_addr[2:0], exp_i);
               end
               mon_checks++;
               if (prev_acc) begin
                  mon_errors++;
                  $display("FAIL R8 write-back began on store edge actual=1 expected=0");
               end
               last_cl = int'(mem_addr[2:0]);
            end else begin
               rd_cnt++;
            end
         end
         if (mem_ack) begin
            outst = 1'b0;
            if (mem_we) sdirty[mem_addr[2:0]] = 1'b0;
         end
         if (acc) sdirty[cpu_addr[2:0]] = 1'b1;
         prev_req = mem_req;
         prev_acc = acc;
      end
   end

   // stimulus-side checking
   int          checks = 0, errors = 0;
   logic [31:0] gold [DEPTH];
   logic        bval [LINES];
   int          btag [LINES];
   logic        done = 1'b0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic access(string req, bit wr, int a, logic [31:0] wd);
      int  idx;
      bit  exp_hit;
      int  rd0;
      idx     = a % LINES;
      exp_hit = bval[idx] && (btag[idx] == a / LINES);
      @(negedge clk);
      rd0 = rd_cnt;
      cpu_valid = 1'b1; cpu_write = wr; cpu_addr = ADDR_W'(a); cpu_wdata = wd;
      #1;
      chk(req, "first-cycle hit", 32'(cpu_hit), 32'(exp_hit));
      if (exp_hit) chk("R4", "ready on hit", 32'(cpu_ready), 32'd1);
      if (!wr && !exp_hit) chk("R12", "ready low on read miss", 32'(cpu_ready), 32'd0);
      while (!cpu_ready) begin
         @(negedge clk);
         #1;
      end
      if (!wr) begin
         chk("R5", "read data", cpu_rdata, gold[a]);
         chk("R5", "hit at completion", 32'(cpu_hit), 32'd1);
         chk("R5", "memory reads", 32'(rd_cnt - rd0), exp_hit ? 32'd0 : 32'd1);
      end else begin
         gold[a] = wd;
         chk("R6", "write hit flag", 32'(cpu_hit), 32'(exp_hit));
         chk("R6", "no memory read on write", 32'(rd_cnt - rd0), 32'd0);
      end
      bval[idx] = 1'b1;
      btag[idx] = a / LINES;
      @(posedge clk);
      #1;
      cpu_valid = 1'b0;
   endtask

   task automatic compare_mem(string req, int lo, int hi);
      for (int i = lo; i <= hi; i++) chk(req, $sformatf("memory word %0d", i), mem[i], gold[i]);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
      chk("R9", "busy after request", 32'(flush_busy), 32'd1);
      while (flush_busy) @(negedge clk);
      for (int i = 0; i < LINES; i++) bval[i] = 1'b0;
      compare_mem("R9", 0, DEPTH - 1);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) gold[i] = seed(i);
      for (int i = 0; i < LINES; i++) begin bval[i] = 1'b0; btag[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R12", "reset ready", 32'(cpu_ready), 32'd0);
      chk("R11", "reset mem_req", 32'(mem_req), 32'd0);
      chk("R9", "reset flush_busy", 32'(flush_busy), 32'd0);

      access("R3", 0, 0, '0);
      access("R4", 0, 0, '0);
      access("R1", 0, 8, '0);
      access("R1", 0, 16, '0);
      access("R1", 0, 0, '0);
      for (int a = 0; a < 64; a++) access("R1", 0, a, '0);
      for (int i = 0; i < 32; i++) access("R2", 0, (i * 8 + i / 8) % 64, '0);

      for (int a = 0; a < 32; a++) access("R6", 1, a, 32'h1000 + 32'(a) * 37);
      for (int a = 0; a < 32; a++) access("R7", 0, a, '0);
      for (int a = 24; a < 32; a++) access("R8", 1, a, 32'h2000 + 32'(a));
      repeat (100) @(negedge clk);
      compare_mem("R8", 0, 63);

      access("R6", 1, 3, 32'hCAFE_0003);
      access("R7", 0, 11, '0);
      chk("R7", "dirty word written back before fill", mem[3], 32'hCAFE_0003);
      access("R7", 0, 3, '0);

      access("R6", 1, 40, 32'h4000_0040);
      access("R6", 1, 41, 32'h4000_0041);
      access("R6", 1, 50, 32'h4000_0050);
      do_flush();
      access("R9", 0, 40, '0);

      for (int i = 0; i < 64; i++) begin
         if (i % 3 == 0) access("R5", 1, (i * 29 + 7) % 96, 32'h7700_0000 + 32'(i));
         else            access("R5", 0, (i * 29 + 7) % 96, '0);
      end
      do_flush();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors + mon_errors + 1, checks + mon_checks + 1);
         $finish;
      end
   end

endmodule